// File: doc/BRIEF.md
# Mailbox Memory Writer with Running CRC-16

A management host uses this block to load 32-bit words into an on-chip memory through a small bank of 16-bit registers. The host first sets a word address as two 16-bit halves. For each word it then stages the two data halves and writes an execute-write command to the control register. The block places that word on a memory write port, moves its address pointer on by one word, and folds the four bytes of the word into a CRC-16.

When a burst is finished, the host reads the CRC register and compares it with a checksum computed over the same words on the host side. A clear bit in the control register returns the CRC to its initial value before a new burst. The CRC engine takes a parameterised number of bytes per clock. While it works, a busy flag is raised and further commands are dropped.

Top module: `mbox_crc_writer`

## Requirements
- R1: After reset the CRC reads 0x0000, busy is low, mem_we is low, and the address pointer and both staged data halves read zero.
- R2: The register selectors are 0 control, 1 address high half, 2 address low half, 3 data high half, 4 data low half and 5 CRC. Writing a selector from 1 to 4 replaces that 16-bit half. Reading selectors 1 to 5 returns the current value. Reading control returns busy in bit 3 and zeros elsewhere.
- R3: The address high and low registers set bits 31:16 and 15:0 of the word-address pointer directly.
- R4: A control write with bit 1 (execute) and bit 2 (write) both set, while busy is low, raises mem_we for exactly one cycle on the next clock. That cycle carries mem_addr equal to the pointer and mem_wdata equal to {data high, data low}.
- R5: Each committed word advances the pointer by one, carrying from the low half into the high half.
- R6: Each committed word updates the CRC with polynomial 0x1021, MSB-first and unreflected, feeding the word's bytes from bits 31:24 down to bits 7:0.
- R7: After a commit, busy stays high for 4/BYTES_PER_STEP cycles. The CRC reflects the word once busy has fallen.
- R8: A commit request received while busy is high writes nothing and changes neither the pointer nor the CRC.
- R9: A control write with execute set and write clear causes no memory write and leaves the pointer and the CRC unchanged.
- R10: A control write with bit 0 set while busy is low returns the CRC to 0x0000. While busy is high, this bit is ignored.
- R11: A control write with bits 0, 1 and 2 all set clears the CRC and then folds in the committed word, so the result is the CRC of that word alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register selector for writes |
| reg_wr_data | input | 16 | Register write data |
| reg_rd_sel | input | 3 | Register selector for reads |
| reg_rd_data | output | 16 | Combinational read data |
| busy | output | 1 | CRC engine working; commands are ignored |
| mem_we | output | 1 | One-cycle memory write enable |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |

## Verification
A corrupted pointer shows up on the next mem_we cycle, because mem_addr no longer follows the sequence of previous writes. A bad CRC state or a wrong byte order cannot be seen until the CRC is read after busy falls, and a single error then spoils every later value of the burst. A busy counter that is off by one changes the measured busy length at once, and a dropped or doubled commit appears as a missing or extra mem_we pulse in the same cycle.

// File: rtl/mbox_crc_pkg.sv
package mbox_crc_pkg;

   localparam int HALF_W    = 16;
   localparam int WORD_W    = 2 * HALF_W;
   localparam int SEL_W     = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_CTRL    = 3'd0,
      SEL_ADDR_HI = 3'd1,
      SEL_ADDR_LO = 3'd2,
      SEL_DATA_HI = 3'd3,
      SEL_DATA_LO = 3'd4,
      SEL_CRC     = 3'd5
   } reg_sel_e;

   localparam int CTRL_CLR_BIT   = 0;
   localparam int CTRL_EXEC_BIT  = 1;
   localparam int CTRL_WRITE_BIT = 2;
   localparam int CTRL_BUSY_BIT  = 3;

   // One byte folded into a 16-bit CRC, MSB-first, no reflection.
   function automatic logic [15:0] crc16_fold_byte(input logic [15:0] c_in,
                                                   input logic [7:0]  b,
                                                   input logic [15:0] poly);
      logic [15:0] c;
      c = c_in ^ {b, 8'h00};
      for (int k = 0; k < 8; k++) begin
         c = c[15] ? ((c << 1) ^ poly) : (c << 1);
      end
      return c;
   endfunction

endpackage

// File: rtl/mbox_regs.sv
module mbox_regs
   import mbox_crc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [HALF_W-1:0] wr_data,
   input  logic              engine_busy,
   output logic [WORD_W-1:0] ptr,
   output logic [WORD_W-1:0] staged,
   output logic              commit,
   output logic              crc_clear
);

   logic ctrl_wr;

   assign ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
   assign commit    = ctrl_wr && !engine_busy &&
                      wr_data[CTRL_EXEC_BIT] && wr_data[CTRL_WRITE_BIT];
   assign crc_clear = ctrl_wr && !engine_busy && wr_data[CTRL_CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         staged <= '0;
      end else if (commit) begin
         ptr <= ptr + WORD_W'(1);
      end else if (wr_en) begin
         case (reg_sel_e'(wr_sel))
            SEL_ADDR_HI: ptr[WORD_W-1:HALF_W]    <= wr_data;
            SEL_ADDR_LO: ptr[HALF_W-1:0]         <= wr_data;
            SEL_DATA_HI: staged[WORD_W-1:HALF_W] <= wr_data;
            SEL_DATA_LO: staged[HALF_W-1:0]      <= wr_data;
            default: ;
         endcase
      end
   end

   assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> ptr == $past(ptr) + WORD_W'(1));

   assert_no_commit_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (engine_busy && !wr_en) |=> $stable(ptr));

endmodule

// File: rtl/mbox_crc_engine.sv
module mbox_crc_engine
   import mbox_crc_pkg::*;
#(
   parameter logic [15:0] CRC_POLY       = 16'h1021,
   parameter logic [15:0] CRC_INIT       = 16'h0000,
   parameter int          BYTES_PER_STEP = 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              clear,
   input  logic [WORD_W-1:0] word,
   output logic [15:0]       crc,
   output logic              busy
);

   localparam int WORD_BYTES = WORD_W / 8;
   localparam int STEPS      = WORD_BYTES / BYTES_PER_STEP;
   localparam int CNT_W      = $clog2(STEPS + 1);
   localparam int STEP_BITS  = 8 * BYTES_PER_STEP;

   generate
      if (BYTES_PER_STEP != 1 && BYTES_PER_STEP != 2 && BYTES_PER_STEP != 4) begin : g_bad_step
         $error("BYTES_PER_STEP must be 1, 2 or 4");
      end
      if (CRC_POLY[0] != 1'b1) begin : g_bad_poly
         $error("CRC_POLY must have its constant term set");
      end
   endgenerate

   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] shreg_next;
   logic [CNT_W-1:0]  left;
   logic [15:0]       crc_next;

   always_comb begin
      crc_next = crc;
      for (int i = 0; i < BYTES_PER_STEP; i++) begin
         crc_next = crc16_fold_byte(crc_next, shreg[WORD_W-1-8*i -: 8], CRC_POLY);
      end
   end

   generate
      if (STEPS == 1) begin : g_single
         assign shreg_next = '0;
      end else begin : g_multi
         assign shreg_next = {shreg[WORD_W-STEP_BITS-1:0], {STEP_BITS{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crc   <= CRC_INIT;
         busy  <= 1'b0;
         left  <= '0;
         shreg <= '0;
      end else begin
         if (clear) crc <= CRC_INIT;
         if (start) begin
            shreg <= word;
            left  <= CNT_W'(STEPS);
            busy  <= 1'b1;
         end else if (busy) begin
            crc   <= crc_next;
            shreg <= shreg_next;
            left  <= left - CNT_W'(1);
            if (left == CNT_W'(1)) busy <= 1'b0;
         end
      end
   end

   assert_crc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !clear) |=> $stable(crc));

   assert_clear_init_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> crc == CRC_INIT);

   assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

   assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

endmodule

// File: rtl/mbox_crc_writer.sv
module mbox_crc_writer
   import mbox_crc_pkg::*;
#(
   parameter logic [15:0] CRC_POLY       = 16'h1021,
   parameter logic [15:0] CRC_INIT       = 16'h0000,
   parameter int          BYTES_PER_STEP = 1
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr_en,
   input  logic [2:0]  reg_wr_sel,
   input  logic [15:0] reg_wr_data,
   input  logic [2:0]  reg_rd_sel,
   output logic [15:0] reg_rd_data,
   output logic        busy,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata
);

   logic [WORD_W-1:0] ptr;
   logic [WORD_W-1:0] staged;
   logic              commit;
   logic              crc_clear;
   logic [15:0]       crc;

   mbox_regs u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (reg_wr_en),
      .wr_sel      (reg_wr_sel),
      .wr_data     (reg_wr_data),
      .engine_busy (busy),
      .ptr         (ptr),
      .staged      (staged),
      .commit      (commit),
      .crc_clear   (crc_clear)
   );

   mbox_crc_engine #(
      .CRC_POLY       (CRC_POLY),
      .CRC_INIT       (CRC_INIT),
      .BYTES_PER_STEP (BYTES_PER_STEP)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .start (commit),
      .clear (crc_clear),
      .word  (staged),
      .crc   (crc),
      .busy  (busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= commit;
         if (commit) begin
            mem_addr  <= ptr;
            mem_wdata <= staged;
         end
      end
   end

   always_comb begin
      reg_rd_data = '0;
      case (reg_sel_e'(reg_rd_sel))
         SEL_CTRL:    reg_rd_data[CTRL_BUSY_BIT] = busy;
         SEL_ADDR_HI: reg_rd_data = ptr[WORD_W-1:HALF_W];
         SEL_ADDR_LO: reg_rd_data = ptr[HALF_W-1:0];
         SEL_DATA_HI: reg_rd_data = staged[WORD_W-1:HALF_W];
         SEL_DATA_LO: reg_rd_data = staged[HALF_W-1:0];
         SEL_CRC:     reg_rd_data = crc;
         default:     reg_rd_data = '0;
      endcase
   end

   assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   assert_we_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ptr == mem_addr + 32'd1);

   assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr_en && reg_wr_sel == SEL_CTRL &&
       reg_wr_data[CTRL_EXEC_BIT] && reg_wr_data[CTRL_WRITE_BIT]) |=> !mem_we);

   assert_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_wr_sel == SEL_CTRL && !reg_wr_data[CTRL_WRITE_BIT]) |=> !mem_we);

endmodule

// File: tb/mbox_crc_writer_bench.sv
module mbox_crc_writer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int STEPS      = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_wr_sel = '0;
   logic [15:0] reg_wr_data = '0;
   logic [2:0]  reg_rd_sel = '0;
   logic [15:0] reg_rd_data;
   logic        busy;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbox_crc_writer u_mbox_crc_writer (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_wr_en   (reg_wr_en),
      .reg_wr_sel  (reg_wr_sel),
      .reg_wr_data (reg_wr_data),
      .reg_rd_sel  (reg_rd_sel),
      .reg_rd_data (reg_rd_data),
      .busy        (busy),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata)
   );

   function automatic logic [15:0] ref_crc(input logic [15:0] c_in, input logic [31:0] w);
      logic [15:0] c;
      c = c_in;
      for (int n = 3; n >= 0; n--) begin
         for (int b = 7; b >= 0; b--) begin
            logic fb;
            fb = c[15] ^ w[8*n+b];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
         end
      end
      return c;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [15:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] sel, output logic [15:0] d);
      reg_rd_sel = sel;
      #1;
      d = reg_rd_data;
   endtask

   task automatic rd_ptr(output logic [31:0] p);
      logic [15:0] h, l;
      rd(3'd1, h);
      rd(3'd2, l);
      p = {h, l};
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 100) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic stage(input logic [31:0] w);
      wr(3'd3, w[31:16]);
      wr(3'd4, w[15:0]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic [31:0] p;
      logic [15:0] exp_crc;
      logic [31:0] exp_ptr;
      int n;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd5, d); check("R1 crc", 32'(d), 32'h0);
      check("R1 busy", 32'(busy), 0);
      check("R1 mem_we", 32'(mem_we), 0);
      rd_ptr(p); check("R1 pointer", p, 0);
      rd(3'd3, d); check("R1 data hi", 32'(d), 0);
      rd(3'd4, d); check("R1 data lo", 32'(d), 0);

      // R2 / R3 register readback
      wr(3'd1, 16'h0000); wr(3'd2, 16'hFFFA);
      rd_ptr(p); check("R3 pointer halves", p, 32'h0000FFFA);
      stage(32'hA5C3_0F1E);
      rd(3'd3, d); check("R2 data hi", 32'(d), 32'hA5C3);
      rd(3'd4, d); check("R2 data lo", 32'(d), 32'h0F1E);
      rd(3'd0, d); check("R2 ctrl idle", 32'(d), 0);

      // R4..R7 burst sweep crossing the 16-bit carry
      exp_crc = 16'h0;
      exp_ptr = 32'h0000FFFA;
      for (int i = 0; i < 16; i++) begin
         logic [31:0] w;
         w = (32'(i) * 32'h9E37_79B9) ^ {8'(i), 8'(255 - i), 8'(i * 7), 8'(i * 13)};
         stage(w);
         wr(3'd0, 16'h0006);
         check("R4 mem_we", 32'(mem_we), 1);
         check("R4 mem_addr", mem_addr, exp_ptr);
         check("R4 mem_wdata", mem_wdata, w);
         rd(3'd0, d); check("R2 ctrl busy bit", 32'(d), 32'h8);
         wait_idle(n);
         check("R7 busy length", 32'(n), STEPS);
         exp_crc = ref_crc(exp_crc, w);
         exp_ptr = exp_ptr + 1;
         rd(3'd5, d); check("R6 crc", 32'(d), 32'(exp_crc));
         rd_ptr(p); check("R5 pointer step", p, exp_ptr);
      end

      // R8 commit while busy ignored
      stage(32'h1234_5678);
      wr(3'd0, 16'h0006);
      wr(3'd0, 16'h0006);
      check("R8 no second write", 32'(mem_we), 0);
      wait_idle(n);
      exp_crc = ref_crc(exp_crc, 32'h1234_5678);
      exp_ptr = exp_ptr + 1;
      rd(3'd5, d); check("R8 crc once", 32'(d), 32'(exp_crc));
      rd_ptr(p); check("R8 pointer once", p, exp_ptr);

      // R10 clear while busy ignored
      stage(32'hDEAD_BEEF);
      wr(3'd0, 16'h0006);
      wr(3'd0, 16'h0001);
      wait_idle(n);
      exp_crc = ref_crc(exp_crc, 32'hDEAD_BEEF);
      exp_ptr = exp_ptr + 1;
      rd(3'd5, d); check("R10 clear ignored when busy", 32'(d), 32'(exp_crc));

      // R9 execute without write
      stage(32'hCAFE_F00D);
      wr(3'd0, 16'h0002);
      check("R9 no mem_we", 32'(mem_we), 0);
      check("R9 not busy", 32'(busy), 0);
      @(negedge clk);
      rd(3'd5, d); check("R9 crc unchanged", 32'(d), 32'(exp_crc));
      rd_ptr(p); check("R9 pointer unchanged", p, exp_ptr);

      // R10 clear when idle
      wr(3'd0, 16'h0001);
      rd(3'd5, d); check("R10 clear", 32'(d), 0);
      check("R10 no mem_we", 32'(mem_we), 0);

      // R11 clear together with commit
      wr(3'd0, 16'h0006);
      wait_idle(n);
      wr(3'd0, 16'h0007);
      check("R11 mem_we", 32'(mem_we), 1);
      wait_idle(n);
      rd(3'd5, d); check("R11 crc of single word", 32'(d), 32'(ref_crc(16'h0, 32'hCAFE_F00D)));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule